// File: doc/BRIEF.md
# Interlocked Serial Port Control Register

This block is a single 16-bit control register on a codec's internal register bus. It sits at index 6Ah. It holds the enables and the data format for a serial audio output port. A simple synchronous interface carries accesses: an address, write data, a write strobe and a registered read-data bus.

Three enables are stored: a master data-output enable, a second-output enable and a serial clock enable. A 2-bit format select is stored beside them. Each enable can only be turned on while status flags from elsewhere in the codec allow it:

- The master enable needs the modem-enable flag.
- The second output needs the master enable and a clear S/PDIF flag.
- The clock needs the master enable and a clear amplifier power-down flag.

When the master enable drops, both dependent enables clear with it. A blocked bit reads back as zero. The stored enables and format drive the serial transmitter directly.

Top module: `sport_ctl_reg`

## Requirements
- R1: Only a write with address 7'h6A changes the register; writes to other addresses leave it unchanged, and a read of any other address returns 0000h.
- R2: Synchronous active-high reset clears the register to 0000h and drives all four control outputs to 0.
- R3: Read data is registered: the value for the address presented at one clock edge appears after that edge. Bit 15 is the master enable, bit 3 the second-output enable, bit 2 the clock enable and bits 1:0 the format; bits 14:4 always read 0.
- R4: The master enable is set only while `modem_ok` is 1; with `modem_ok` at 0 a write of 1 to bit 15 is ignored, and bit 15 reads 0.
- R5: The second-output enable is set only when the master enable is 1 and `spdif_on` is 0. The master value used is the one being written in the same cycle when bit 15 is written together with it. Otherwise the write of bit 3 is ignored.
- R6: The clock enable is set only when the master enable (taken the same way as in R5) is 1 and `amp_pd` is 0; otherwise the write of bit 2 is ignored.
- R7: Whenever the master enable becomes 0, both dependent enables are 0 after the same clock edge. This covers a write of 0 and also a fall of `modem_ok`, which clears the master enable at the next edge.
- R8: If a dependent bit's blocking flag rises while the bit is set, a read in that cycle returns the bit as 0, and the stored bit is cleared at the next edge; it stays clear when the flag falls again.
- R9: The format field takes any written value regardless of the status flags and drives `ser_fmt` (0 two-channel standard, 1 left-justified, 2 right-justified 20-bit, 3 right-justified 16-bit).
- R10: `ser_en`, `out2_en`, `sclk_en` and `ser_fmt` equal the stored bits 15, 3, 2 and 1:0, updating at the write edge; `out2_en` and `sclk_en` are never 1 while `ser_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 7 | Register index |
| reg_wdata | input | 16 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rdata | output | 16 | Registered read data |
| modem_ok | input | 1 | Modem-enable status flag |
| spdif_on | input | 1 | S/PDIF transmitter enable flag |
| amp_pd | input | 1 | External amplifier power-down flag |
| ser_en | output | 1 | Master serial data output enable |
| out2_en | output | 1 | Second serial output enable |
| sclk_en | output | 1 | Serial clock output enable |
| ser_fmt | output | 2 | Serial data format select |

## Verification
A read can fall in the same cycle as a dependent bit's blocking flag rising. In that cycle the readback gating and the automatic clear both act on the same bit. The bench provokes this by raising `spdif_on` in the same cycle as a read of a register whose second output is enabled. It then judges two results: the returned word must already show bit 3 as 0, and `out2_en` must be low right after that edge. A second collision, tested by writing bits 15 and 3 together from a cleared state, shows that the interlock takes the master value being written.

// File: rtl/sport_ctl_pkg.sv
package sport_ctl_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 7;
  localparam logic [ADDR_W-1:0] CTL_IDX = 7'h6A;

  localparam int MST_BIT  = 15;
  localparam int OUT2_BIT = 3;
  localparam int SCK_BIT  = 2;
  localparam int FMT_LO   = 0;
  localparam int FMT_W    = 2;
  localparam int NDEP     = 2;

  typedef enum logic [FMT_W-1:0] {
    FMT_STD  = 2'd0,
    FMT_LJ   = 2'd1,
    FMT_RJ20 = 2'd2,
    FMT_RJ16 = 2'd3
  } fmt_e;

  typedef struct packed {
    logic             mst;
    logic             out2;
    logic             sck;
    logic [FMT_W-1:0] fmt;
  } ctl_t;
endpackage

// File: rtl/sport_ctl_decode.sv
module sport_ctl_decode #(
  parameter int ADDR_W = sport_ctl_pkg::ADDR_W,
  parameter logic [ADDR_W-1:0] REG_IDX = sport_ctl_pkg::CTL_IDX
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic              wr_hit,
  output logic              rd_hit
);
  logic hit;
  assign hit    = (addr == REG_IDX);
  assign wr_hit = hit & wr;
  assign rd_hit = hit;
endmodule

// File: rtl/sport_ctl_state.sv
module sport_ctl_state
  import sport_ctl_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_hit,
  input  logic [DW-1:0] wdata,
  input  logic          modem_ok,
  input  logic          spdif_on,
  input  logic          amp_pd,
  output ctl_t          q
);
  localparam int DEP_POS [NDEP] = '{OUT2_BIT, SCK_BIT};

  logic            mst_n;
  logic [NDEP-1:0] dep_cur, dep_wr, dep_blk, dep_n;
  logic [FMT_W-1:0] fmt_n;
  logic            unused_bits;

  assign unused_bits = ^wdata;
  assign dep_cur = {q.sck, q.out2};
  assign dep_blk = {amp_pd, spdif_on};

  // Master enable is held only while the modem flag allows it.
  assign mst_n = modem_ok & (wr_hit ? wdata[MST_BIT] : q.mst);

  // Each dependent bit uses the next master value, so a write that sets
  // master and a dependent together is judged on the written master.
  for (genvar g = 0; g < NDEP; g++) begin : g_dep
    assign dep_wr[g] = wdata[DEP_POS[g]];
    assign dep_n[g]  = mst_n & ~dep_blk[g] & (wr_hit ? dep_wr[g] : dep_cur[g]);
  end

  assign fmt_n = wr_hit ? wdata[FMT_LO +: FMT_W] : q.fmt;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      q.mst  <= mst_n;
      q.out2 <= dep_n[0];
      q.sck  <= dep_n[1];
      q.fmt  <= fmt_n;
    end
  end
endmodule

// File: rtl/sport_ctl_rdback.sv
module sport_ctl_rdback
  import sport_ctl_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_hit,
  input  ctl_t          q,
  input  logic          modem_ok,
  input  logic          spdif_on,
  input  logic          amp_pd,
  output logic [DW-1:0] rdata
);
  logic          mst_v, out2_v, sck_v;
  logic [DW-1:0] view;

  assign mst_v  = q.mst & modem_ok;
  assign out2_v = q.out2 & mst_v & ~spdif_on;
  assign sck_v  = q.sck & mst_v & ~amp_pd;

  always_comb begin
    view                      = '0;
    view[MST_BIT]             = mst_v;
    view[OUT2_BIT]            = out2_v;
    view[SCK_BIT]             = sck_v;
    view[FMT_LO +: FMT_W]     = q.fmt;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_hit ? view : '0;
  end
endmodule

// File: rtl/sport_ctl_reg.sv
module sport_ctl_reg
  import sport_ctl_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter logic [AW-1:0] REG_IDX = CTL_IDX
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  input  logic             reg_wr,
  output logic [DW-1:0]    reg_rdata,
  input  logic             modem_ok,
  input  logic             spdif_on,
  input  logic             amp_pd,
  output logic             ser_en,
  output logic             out2_en,
  output logic             sclk_en,
  output logic [FMT_W-1:0] ser_fmt
);
  logic wr_hit, rd_hit;
  ctl_t q;

  sport_ctl_decode #(.ADDR_W(AW), .REG_IDX(REG_IDX)) dec_i (
    .addr   (reg_addr),
    .wr     (reg_wr),
    .wr_hit (wr_hit),
    .rd_hit (rd_hit)
  );

  sport_ctl_state #(.DW(DW)) st_i (
    .clk      (clk),
    .rst      (rst),
    .wr_hit   (wr_hit),
    .wdata    (reg_wdata),
    .modem_ok (modem_ok),
    .spdif_on (spdif_on),
    .amp_pd   (amp_pd),
    .q        (q)
  );

  sport_ctl_rdback #(.DW(DW)) rb_i (
    .clk      (clk),
    .rst      (rst),
    .rd_hit   (rd_hit),
    .q        (q),
    .modem_ok (modem_ok),
    .spdif_on (spdif_on),
    .amp_pd   (amp_pd),
    .rdata    (reg_rdata)
  );

  assign ser_en  = q.mst;
  assign out2_en = q.out2;
  assign sclk_en = q.sck;
  assign ser_fmt = q.fmt;
endmodule

// File: rtl/sport_ctl_reg_chk.sv
module sport_ctl_reg_chk
  import sport_ctl_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter logic [AW-1:0] REG_IDX = CTL_IDX
) (
  input logic             clk,
  input logic             rst,
  input logic [AW-1:0]    reg_addr,
  input logic             reg_wr,
  input logic [DW-1:0]    reg_rdata,
  input logic             modem_ok,
  input logic             spdif_on,
  input logic             amp_pd,
  input logic             ser_en,
  input logic             out2_en,
  input logic             sclk_en,
  input logic [FMT_W-1:0] ser_fmt
);
  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ser_en && !out2_en && !sclk_en && ser_fmt == '0)); // R2
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[MST_BIT-1:OUT2_BIT+1] == '0); // R3
  AST_MST_NEEDS_MODEM: assert property (@(posedge clk) disable iff (rst)
    ser_en |-> $past(modem_ok)); // R4
  AST_OUT2_INTERLOCK: assert property (@(posedge clk) disable iff (rst)
    out2_en |-> (ser_en && !$past(spdif_on))); // R5
  AST_SCK_INTERLOCK: assert property (@(posedge clk) disable iff (rst)
    sclk_en |-> (ser_en && !$past(amp_pd))); // R6
  AST_MODEM_DROP: assert property (@(posedge clk) disable iff (rst)
    !modem_ok |=> (!ser_en && !out2_en && !sclk_en)); // R7
  AST_FLAG_GATES_READ: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == REG_IDX && spdif_on) |=> !reg_rdata[OUT2_BIT]); // R8
  AST_FMT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_addr == REG_IDX) |=> $stable(ser_fmt)); // R9
  AST_OTHER_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_addr != REG_IDX) |=> reg_rdata == '0); // R1
endmodule

bind sport_ctl_reg sport_ctl_reg_chk #(.DW(DW), .AW(AW), .REG_IDX(REG_IDX)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rdata (reg_rdata),
  .modem_ok  (modem_ok),
  .spdif_on  (spdif_on),
  .amp_pd    (amp_pd),
  .ser_en    (ser_en),
  .out2_en   (out2_en),
  .sclk_en   (sclk_en),
  .ser_fmt   (ser_fmt)
);

// File: tb/sport_ctl_reg_tb_top.sv
module sport_ctl_reg_tb_top;
  localparam logic [6:0] IDX = 7'h6A;
  localparam int NVEC = 8;
  // {modem_ok, spdif_on, amp_pd, write data, expected read}
  localparam logic [34:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 16'h800F, 16'h0003},
    {1'b1, 1'b0, 1'b0, 16'h800F, 16'h800F},
    {1'b1, 1'b1, 1'b0, 16'h800F, 16'h8007},
    {1'b1, 1'b0, 1'b1, 16'h800F, 16'h800B},
    {1'b1, 1'b0, 1'b0, 16'h000D, 16'h0001},
    {1'b1, 1'b0, 1'b0, 16'hFFF2, 16'h8002},
    {1'b1, 1'b0, 1'b0, 16'h8004, 16'h8004},
    {1'b1, 1'b0, 1'b0, 16'h0000, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_rdata;
  logic        modem_ok = 1'b0, spdif_on = 1'b0, amp_pd = 1'b0;
  logic        ser_en, out2_en, sclk_en;
  logic [1:0]  ser_fmt;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sport_ctl_reg dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rdata(reg_rdata), .modem_ok(modem_ok),
    .spdif_on(spdif_on), .amp_pd(amp_pd), .ser_en(ser_en),
    .out2_en(out2_en), .sclk_en(sclk_en), .ser_fmt(ser_fmt)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [6:0] a, output logic [15:0] v);
    reg_addr = a; reg_wr = 1'b0;
    @(negedge clk);
    v = reg_rdata;
  endtask

  function automatic logic [15:0] outs();
    return {ser_en, 11'b0, out2_en, sclk_en, ser_fmt};
  endfunction

  initial begin
    logic [15:0] rv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R2 outputs after reset", outs(), 16'h0000);
    rd_reg(IDX, rv);
    chk("R2 read after reset", rv, 16'h0000);

    // Table walk: R3 R4 R5 R6 R7 R9 R10
    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] wd, ex;
      {modem_ok, spdif_on, amp_pd, wd, ex} = VEC[i];
      wr_reg(IDX, wd);
      chk($sformatf("R10 outputs vec %0d", i), outs(), ex);
      rd_reg(IDX, rv);
      chk($sformatf("R3/R4/R5/R6/R9 read vec %0d", i), rv, ex);
    end

    // R5/R6: master and dependents written together from cleared state
    modem_ok = 1'b1; spdif_on = 1'b0; amp_pd = 1'b0;
    wr_reg(IDX, 16'h800C);
    rd_reg(IDX, rv);
    chk("R5 R6 same-cycle master", rv, 16'h800C);
    // R7: clearing master by write drops dependents
    wr_reg(IDX, 16'h7FFF);
    chk("R7 master write 0 outputs", outs(), 16'h0003);

    // R7: modem flag falls
    wr_reg(IDX, 16'h800F);
    modem_ok = 1'b0;
    @(negedge clk);
    chk("R7 modem drop outputs", outs(), 16'h0003);
    modem_ok = 1'b1;
    rd_reg(IDX, rv);
    chk("R4 master stays clear", rv, 16'h0003);

    // R8: blocking flag rises in the same cycle as a read
    wr_reg(IDX, 16'h800F);
    spdif_on = 1'b1;
    rd_reg(IDX, rv);
    chk("R8 gated read", rv, 16'h8007);
    chk("R8 out2 cleared", {15'b0, out2_en}, 16'h0000);
    spdif_on = 1'b0;
    rd_reg(IDX, rv);
    chk("R8 stays clear", rv, 16'h8007);

    // R1: other addresses
    wr_reg(7'h68, 16'h0000);
    rd_reg(IDX, rv);
    chk("R1 other write ignored", rv, 16'h8007);
    rd_reg(7'h68, rv);
    chk("R1 other read zero", rv, 16'h0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule